// File: doc/BRIEF.md
# Two-Stage Log-Domain Max-Star Combiner

This block merges two competing path metrics the way a soft-output trellis detector needs it. Each of the two candidates is extended by its own branch increment. The larger of the two extended metrics is kept. A small correction, drawn from a table that follows ln(1+e^-d), is then added, where d is the gap between the two extended metrics. The result is the log of the sum of the two path probabilities rather than just the log of the larger one. Metrics are unsigned, and a larger value means a more likely path.

The work is cut into two register stages so that neither stage is longer than about one compare-select-add. Stage one forms the two saturating sums, compares them, and registers the winner, the gap and which path won. Stage two reads the correction from the gap and performs the final saturating add. A valid flag travels alongside the data. A parameter chooses how stage two is built: either the correction is looked up first and added afterwards, or every possible corrected value is formed in parallel while the lookup runs, and the lookup then selects one of them. Both builds give identical results. Metric normalisation is left to the logic that follows the block. The final add saturates, so an output can never wrap.

Top module: `logsum_pipe`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, out_metric and out_pick_b are all 0.
- R2: An accepted input (in_valid high at a rising edge) gives out_valid high exactly two rising edges later. A cycle with in_valid low gives out_valid low two edges later.
- R3: Each path sum is cand + incr with incr zero-extended, saturating at 2^W-1 (127 for W=7).
- R4: out_pick_b is 1 exactly when sum_b > sum_a. When the sums are equal, path a is kept and out_pick_b is 0.
- R5: Let d = |sum_a - sum_b|. The correction is 3 when d = 0, 2 when 1 <= d <= 3, 1 when 4 <= d <= 7, and 0 when d >= 8.
- R6: out_metric = min(max(sum_a, sum_b) + correction, 2^W-1). It is never smaller than the larger sum and never more than 3 above it.
- R7: While out_valid is low, out_metric and out_pick_b keep their last values.
- R8: A new input may be accepted on every cycle, and each one produces its own result in order.
- R9: The parallel-add build of stage two (PAR_ADD=1) gives bit-identical outputs to the lookup-then-add build (PAR_ADD=0) for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on this cycle are to be processed |
| cand_a | input | W | Survivor metric of path a |
| cand_b | input | W | Survivor metric of path b |
| incr_a | input | BW | Branch increment for path a |
| incr_b | input | BW | Branch increment for path b |
| out_valid | output | 1 | out_metric and out_pick_b carry a fresh result |
| out_metric | output | W | Corrected combined metric |
| out_pick_b | output | 1 | 1 when path b had the strictly larger sum |

## Verification
On every cycle the assertions check the two-cycle valid latency, the hold of the outputs during idle cycles, and that each result lies between the registered winner and that winner plus the largest correction. Only the bench scenarios show the exact values: each band edge of the correction table, the tie rule, saturation both in the path sums and in the final add, streams of back-to-back inputs, and the agreement of the two stage-two builds.

// File: rtl/logsum_pkg.sv
// Shared constants and the correction table of the max-star combiner.
// Assumes the gap fed to corr_lut fits in LUT_IN_W bits (W <= 16).
package logsum_pkg;

    localparam int LUT_IN_W = 16;
    localparam int CORR_W   = 2;
    localparam logic [CORR_W-1:0] CORR_PEAK = 2'd3;

    // Gap thresholds in LSBs where the correction steps down by one.
    localparam int EDGE_HI  = 1;
    localparam int EDGE_MID = 4;
    localparam int EDGE_LO  = 8;

    // Quantised ln(1+e^-d), one LSB = 0.25 nat; reaches zero at EDGE_LO.
    function automatic logic [CORR_W-1:0] corr_lut(input logic [LUT_IN_W-1:0] d);
        if (d < LUT_IN_W'(EDGE_HI))
            return CORR_PEAK;
        else if (d < LUT_IN_W'(EDGE_MID))
            return 2'd2;
        else if (d < LUT_IN_W'(EDGE_LO))
            return 2'd1;
        else
            return 2'd0;
    endfunction

endpackage

// File: rtl/logsum_stage1.sv
// Stage one: two saturating path adds, compare, select, gap.
// Registers winner, gap and winner index when in_valid is high.
// Assumes BW <= W.
module logsum_stage1 #(
    parameter int W  = 7,
    parameter int BW = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] cand_a,
    input  logic [W-1:0] cand_b,
    input  logic [BW-1:0] incr_a,
    input  logic [BW-1:0] incr_b,
    output logic         s1_valid,
    output logic [W-1:0] s1_max,
    output logic [W-1:0] s1_gap,
    output logic         s1_pick_b
);

    logic [1:0][W-1:0]  cand;
    logic [1:0][BW-1:0] incr;
    logic [1:0][W-1:0]  sum;
    logic               b_wins;
    logic [W-1:0]       win_val;
    logic [W-1:0]       gap_val;

    assign cand = {cand_b, cand_a};
    assign incr = {incr_b, incr_a};

    // One saturating adder per path.
    for (genvar p = 0; p < 2; p++) begin : g_path
        logic [W:0] wide;
        // Extend candidate by its increment and clip at full scale.
        always_comb begin
            wide   = {1'b0, cand[p]} + (W+1)'(incr[p]);
            sum[p] = wide[W] ? {W{1'b1}} : wide[W-1:0];
        end
    end

    // Compare, select the larger (ties keep path a), and form the gap.
    always_comb begin
        b_wins  = sum[1] > sum[0];
        win_val = b_wins ? sum[1] : sum[0];
        gap_val = b_wins ? (sum[1] - sum[0]) : (sum[0] - sum[1]);
    end

    // Pipeline register; data loads only for accepted inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_max    <= '0;
            s1_gap    <= '0;
            s1_pick_b <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_max    <= win_val;
                s1_gap    <= gap_val;
                s1_pick_b <= b_wins;
            end
        end
    end

endmodule

// File: rtl/logsum_stage2.sv
// Stage two: correction lookup from the gap and final saturating add.
// PAR_ADD=0 looks up then adds; PAR_ADD=1 forms all corrected values
// in parallel with the lookup and selects one. Assumes W <= 16.
module logsum_stage2
    import logsum_pkg::*;
#(
    parameter int W       = 7,
    parameter int PAR_ADD = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s1_valid,
    input  logic [W-1:0] s1_max,
    input  logic [W-1:0] s1_gap,
    input  logic         s1_pick_b,
    output logic         out_valid,
    output logic [W-1:0] out_metric,
    output logic         out_pick_b
);

    localparam int NCAND = int'(CORR_PEAK) + 1;

    logic [CORR_W-1:0] corr;
    logic [W-1:0]      result;

    // Correction lookup from the registered gap.
    always_comb corr = corr_lut(LUT_IN_W'(s1_gap));

    if (PAR_ADD == 0) begin : g_serial
        logic [W:0] wide;
        // Add the looked-up correction and clip at full scale.
        always_comb begin
            wide   = {1'b0, s1_max} + (W+1)'(corr);
            result = wide[W] ? {W{1'b1}} : wide[W-1:0];
        end
    end else begin : g_parallel
        logic [NCAND-1:0][W-1:0] pre;
        for (genvar k = 0; k < NCAND; k++) begin : g_cand
            logic [W:0] wide;
            // Precompute winner plus k, clipped, independent of the lookup.
            always_comb begin
                wide   = {1'b0, s1_max} + (W+1)'(k);
                pre[k] = wide[W] ? {W{1'b1}} : wide[W-1:0];
            end
        end
        // Lookup result picks one precomputed sum.
        always_comb result = pre[corr];
    end

    // Output register; holds its value during idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_metric <= '0;
            out_pick_b <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_metric <= result;
                out_pick_b <= s1_pick_b;
            end
        end
    end

endmodule

// File: rtl/logsum_pipe.sv
// Two-stage max-star combiner: max(a+ia, b+ib) + f(|gap|), latency two.
// Assumes BW <= W <= 16; downstream logic normalises metrics.
module logsum_pipe #(
    parameter int W       = 7,
    parameter int BW      = 6,
    parameter int PAR_ADD = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  cand_a,
    input  logic [W-1:0]  cand_b,
    input  logic [BW-1:0] incr_a,
    input  logic [BW-1:0] incr_b,
    output logic          out_valid,
    output logic [W-1:0]  out_metric,
    output logic          out_pick_b
);

    logic         s1_valid;
    logic [W-1:0] s1_max;
    logic [W-1:0] s1_gap;
    logic         s1_pick_b;

    logsum_stage1 #(.W(W), .BW(BW)) u_s1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cand_a    (cand_a),
        .cand_b    (cand_b),
        .incr_a    (incr_a),
        .incr_b    (incr_b),
        .s1_valid  (s1_valid),
        .s1_max    (s1_max),
        .s1_gap    (s1_gap),
        .s1_pick_b (s1_pick_b)
    );

    logsum_stage2 #(.W(W), .PAR_ADD(PAR_ADD)) u_s2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_valid   (s1_valid),
        .s1_max     (s1_max),
        .s1_gap     (s1_gap),
        .s1_pick_b  (s1_pick_b),
        .out_valid  (out_valid),
        .out_metric (out_metric),
        .out_pick_b (out_pick_b)
    );

endmodule

// File: rtl/logsum_pipe_chk.sv
// Property checker for logsum_pipe, attached by bind below.
// Assumes synchronous active-low reset; windows gated by a cycle count.
module logsum_pipe_chk #(
    parameter int W = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_metric,
    input logic         out_pick_b,
    input logic [W-1:0] mid_max
);

    logic [1:0] age;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R2: valid emerges exactly two edges after it is presented.
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R6: result never below the winner registered by stage one.
    a_r6_not_below_max: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd1) && out_valid) |-> (out_metric >= $past(mid_max)));

    // R5: correction adds at most three LSBs.
    a_r5_corr_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd1) && out_valid) |-> ({1'b0, out_metric} <= ({1'b0, $past(mid_max)} + (W+1)'(3))));

    // R7: outputs hold while no fresh result is flagged.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd1) && !out_valid) |-> ($stable(out_metric) && $stable(out_pick_b)));

endmodule

bind logsum_pipe logsum_pipe_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_metric (out_metric),
    .out_pick_b (out_pick_b),
    .mid_max    (s1_max)
);

// File: tb/logsum_pipe_tb.sv
// Self-checking bench: directed corners plus seeded random stream.
module logsum_pipe_tb;

    localparam int W  = 7;
    localparam int BW = 6;
    localparam int FULL = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  cand_a = '0, cand_b = '0;
    logic [BW-1:0] incr_a = '0, incr_b = '0;
    logic          out_valid, out_pick_b, alt_valid, alt_pick_b;
    logic [W-1:0]  out_metric, alt_metric;

    int checks = 0;
    int errors = 0;

    // Expected pipeline history: [1] driven last negedge, [2] two ago.
    logic         h_v [1:2];
    int           h_m [1:2];
    logic         h_p [1:2];
    int           last_m = 0;
    logic         last_p = 1'b0;

    always #2 clk = ~clk;

    logsum_pipe #(.W(W), .BW(BW), .PAR_ADD(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cand_a(cand_a), .cand_b(cand_b), .incr_a(incr_a), .incr_b(incr_b),
        .out_valid(out_valid), .out_metric(out_metric), .out_pick_b(out_pick_b));

    logsum_pipe #(.W(W), .BW(BW), .PAR_ADD(1)) u_alt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cand_a(cand_a), .cand_b(cand_b), .incr_a(incr_a), .incr_b(incr_b),
        .out_valid(alt_valid), .out_metric(alt_metric), .out_pick_b(alt_pick_b));

    function automatic int corr_of(input int d);
        if (d == 0) return 3;
        if (d <= 3) return 2;
        if (d <= 7) return 1;
        return 0;
    endfunction

    function automatic int sat(input int v);
        return (v > FULL) ? FULL : v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare current outputs with history[2], then drive the next input.
    task automatic step(input logic v, input int ca, input int cb, input int ia, input int ib);
        int sa, sb, m;
        logic p;
        @(negedge clk);
        if (h_v[2]) begin
            last_m = h_m[2];
            last_p = h_p[2];
        end
        check("R2 valid", int'(out_valid), int'(h_v[2]));
        check("R3/R5/R6 metric", int'(out_metric), last_m);
        check("R4 pick", int'(out_pick_b), int'(last_p));
        if (!h_v[2]) check("R7 idle hold", int'(out_metric), last_m);
        check("R9 variant metric", int'(alt_metric), int'(out_metric));
        check("R9 variant pick", int'(alt_pick_b), int'(out_pick_b));
        sa = sat(ca + ia);
        sb = sat(cb + ib);
        p  = sb > sa;
        m  = p ? sb : sa;
        m  = sat(m + corr_of(p ? sb - sa : sa - sb));
        in_valid = v;
        cand_a = W'(ca); cand_b = W'(cb);
        incr_a = BW'(ia); incr_b = BW'(ib);
        h_v[2] = h_v[1]; h_m[2] = h_m[1]; h_p[2] = h_p[1];
        h_v[1] = v;      h_m[1] = m;      h_p[1] = p;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        h_v[1] = 1'b0; h_v[2] = 1'b0;
        h_m[1] = 0; h_m[2] = 0; h_p[1] = 1'b0; h_p[2] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset.
        check("R1 valid", int'(out_valid), 0);
        check("R1 metric", int'(out_metric), 0);
        check("R1 pick", int'(out_pick_b), 0);
        rst_n = 1'b1;
        // Directed: tie keeps a with peak correction (R4, R5).
        step(1, 40, 30, 5, 15);
        // R5 band edges: gaps 1, 3, 4, 7, 8, 20.
        step(1, 50, 51, 0, 0);
        step(1, 53, 50, 0, 0);
        step(1, 50, 54, 0, 0);
        step(1, 57, 50, 0, 0);
        step(1, 50, 58, 0, 0);
        step(1, 10, 30, 0, 0);
        // R3: both sums saturate -> tie at 127, final clip (R6).
        step(1, 127, 120, 63, 63);
        // R6: winner 126 plus 2 clipped to 127.
        step(1, 126, 124, 0, 0);
        // R7: idle gap, outputs must hold.
        step(0, 5, 99, 1, 2);
        step(0, 0, 0, 0, 0);
        step(0, 7, 7, 7, 7);
        // R4: b strictly larger by way of its increment.
        step(1, 20, 10, 0, 11);
        // R8: seeded random stream, mostly back-to-back.
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 8) != 0, $urandom % 128, $urandom % 128,
                 $urandom % 64, $urandom % 64);
        end
        // Random near-ties to stress the small-gap bands (R5).
        for (int i = 0; i < 500; i++) begin
            int base;
            base = $urandom % 128;
            step(1, base, sat(base + ($urandom % 10)), $urandom % 4, $urandom % 4);
        end
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule